// File: doc/BRIEF.md
# Programmable Audio Sample Clock Divider

This block divides a fast input clock down to an audio bit, sample or frame clock. A division field `div_val` sets the ratio. When the field is zero the output is stopped and held low. Any nonzero value `v` gives an output period of `v+1` input cycles. The smallest ratio is therefore 2, and the largest is 2^DIV_W.

A parameter picks one of two variants. The frame-clock variant reads a high-time field `high_val` and keeps the output high for `high_val+1` input cycles of each period, which gives any whole-cycle duty ratio up to a fully high period. The plain variant ignores `high_val` and aims for a 50% duty cycle. Both fields are sampled only at a period boundary, so a reprogrammed ratio, duty or stop never cuts a pulse short. The output comes straight from a flop on the input clock.

Top module: `audio_clk_div`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `clk_out` and `running` are both 0.
- R2: While the block is stopped (`div_val` was 0 at the last period boundary, or no period has started since reset), `clk_out` stays 0 and `running` stays 0.
- R3: When the block is stopped and `div_val` is sampled nonzero at a rising edge, `clk_out` goes to 1 on that same edge, and this edge is the first cycle of a new period.
- R4: With a nonzero `div_val` = v, the output period is v+1 input cycles. This covers every v from 1 to 2^DIV_W-1, so the ratio runs from 2 to 2^DIV_W.
- R5: In the frame-clock variant (HAS_HIGH_TIME=1), with `high_val` = h and h <= v, `clk_out` is 1 for the first h+1 cycles of each period and 0 for the remaining v-h cycles.
- R6: In the frame-clock variant, a `high_val` greater than v is treated as v, which keeps the output high for the whole period.
- R7: In the plain variant (HAS_HIGH_TIME=0), `clk_out` is 1 for the first floor((v+1)/2) cycles of each period and 0 for the rest, whatever `high_val` holds.
- R8: A change of `div_val` or `high_val` in the middle of a period has no effect until that period ends. The new values shape the next period.
- R9: If `div_val` is 0 at a period boundary, the output stops at that boundary and then stays low.
- R10: `running` is 1 exactly while a nonzero ratio is in effect, that is, from the starting edge of R3 until the stopping boundary of R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| div_val | input | DIV_W | Division field: 0 stops the output, v>0 divides by v+1 |
| high_val | input | DIV_W | High time minus one, in input cycles (frame-clock variant only) |
| clk_out | output | 1 | Divided clock, driven from a flop |
| running | output | 1 | 1 while a nonzero division ratio is in effect |

## Verification
The bench steps through every division value with every high-time value, including high-time values above the ratio, on both variants at once. A design that started low, counted the period one cycle off, or failed to clamp the high time would show a shifted or truncated waveform. Odd ratios in the plain variant test the floor rule: a design that rounds up would stretch the high phase by one cycle. Separate cases change the ratio, and stop the block, in the middle of a period. A divider that reloaded at once would produce a runt pulse or stop with the output still high.

// File: rtl/acd_pkg.sv
package acd_pkg;
  // limit a requested high index to the last count of the period
  function automatic int unsigned clamp_hi(int unsigned hi, int unsigned lim);
    return (hi > lim) ? lim : hi;
  endfunction
endpackage

// File: rtl/acd_period_ctr.sv
module acd_period_ctr #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_in,
  input  logic [DIV_W-1:0] hi_in,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] cur_div,
  output logic [DIV_W-1:0] cur_hi,
  output logic             idle,
  output logic             at_end,
  output logic             start,
  output logic             stop
);
  logic reload;

  always_comb begin
    idle   = (cur_div == '0);
    at_end = !idle && (cnt == cur_div);
    reload = idle || at_end;
    start  = reload && (div_in != '0);
    stop   = at_end && (div_in == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_div <= '0;
      cur_hi  <= '0;
      cnt     <= '0;
    end else if (reload) begin
      cur_div <= div_in;
      cur_hi  <= hi_in;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: the count never passes the last index of the period
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= cur_div);
  // R8: the ratio in use holds between boundaries
  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!idle && !at_end) |=> $stable(cur_div) && $stable(cur_hi));
endmodule

// File: rtl/acd_high_sel.sv
module acd_high_sel #(
  parameter int DIV_W         = 4,
  parameter bit HAS_HIGH_TIME = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cur_div,
  input  logic [DIV_W-1:0] cur_hi,
  output logic [DIV_W-1:0] hi_last
);
  localparam int EXT_W = DIV_W + 1;

  generate
    if (HAS_HIGH_TIME) begin : g_frame
      always_comb
        hi_last = DIV_W'(acd_pkg::clamp_hi(int'(cur_hi), int'(cur_div)));
    end else begin : g_half
      logic [EXT_W-1:0] half_len;
      always_comb begin
        half_len = ({1'b0, cur_div} + 1'b1) >> 1;
        hi_last  = (cur_div == '0) ? '0 : DIV_W'(half_len - 1'b1);
      end
    end
  endgenerate

  // R6: the last high index never lies beyond the period
  assert_hi_clamp_R6: assert property (@(posedge clk) disable iff (rst)
    hi_last <= cur_div);
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div #(
  parameter int DIV_W         = 4,
  parameter bit HAS_HIGH_TIME = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic [DIV_W-1:0] high_val,
  output logic             clk_out,
  output logic             running
);
  localparam int EXT_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt, cur_div, cur_hi, hi_last;
  logic             idle, at_end, start, stop;
  logic [EXT_W-1:0] next_idx;

  acd_period_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk(clk), .rst(rst), .div_in(div_val), .hi_in(high_val),
    .cnt(cnt), .cur_div(cur_div), .cur_hi(cur_hi),
    .idle(idle), .at_end(at_end), .start(start), .stop(stop)
  );

  acd_high_sel #(.DIV_W(DIV_W), .HAS_HIGH_TIME(HAS_HIGH_TIME)) u_hi (
    .clk(clk), .rst(rst), .cur_div(cur_div), .cur_hi(cur_hi),
    .hi_last(hi_last)
  );

  assign next_idx = {1'b0, cnt} + 1'b1;
  assign running  = !idle;

  always_ff @(posedge clk) begin
    if (rst)                clk_out <= 1'b0;
    else if (start)         clk_out <= 1'b1;
    else if (stop || idle)  clk_out <= 1'b0;
    else                    clk_out <= (next_idx <= {1'b0, hi_last});
  end

  // R2: no pulse while stopped
  assert_idle_low_R2: assert property (@(posedge clk) disable iff (rst)
    !running |-> !clk_out);
  // R3: a nonzero ratio seen while stopped starts a high phase at once
  assert_start_high_R3: assert property (@(posedge clk) disable iff (rst)
    (!running && div_val != '0) |=> (clk_out && running));
  // R3: every period opens high
  assert_period_open_R3: assert property (@(posedge clk) disable iff (rst)
    (running && cnt == '0) |-> clk_out);
  // R9: a zero ratio at a boundary stops the block
  assert_stop_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    (at_end && div_val == '0) |=> (!running && !clk_out));
endmodule

// File: tb/tb_audio_clk_div.sv
module tb_audio_clk_div;
  localparam int W = 4;
  localparam int VMAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] div_val = '0;
  logic [W-1:0] high_val = '0;
  logic out_f, run_f, out_h, run_h;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  audio_clk_div #(.DIV_W(W), .HAS_HIGH_TIME(1'b1)) dut (
    .clk(clk), .rst(rst), .div_val(div_val), .high_val(high_val),
    .clk_out(out_f), .running(run_f));
  audio_clk_div #(.DIV_W(W), .HAS_HIGH_TIME(1'b0)) dut_half (
    .clk(clk), .rst(rst), .div_val(div_val), .high_val(high_val),
    .clk_out(out_h), .running(run_h));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_frame(int i, int v, int h);
    int hh = (h > v) ? v : h;
    return (i % (v + 1)) <= hh;
  endfunction

  function automatic bit exp_half(int i, int v);
    return (i % (v + 1)) < ((v + 1) / 2);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(out_f == 0 && out_h == 0, "R1 out in reset", out_f, 0);
    chk(run_f == 0 && run_h == 0, "R1 running in reset", run_f, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_f == 0 && run_f == 0, "R1 after release", out_f, 0);
    repeat (4) @(negedge clk);
    chk(out_f == 0 && out_h == 0, "R2 idle zero ratio", out_h, 0);

    for (int v = 1; v <= VMAX; v++) begin
      for (int h = 0; h <= VMAX; h++) begin
        div_val = W'(v); high_val = W'(h);
        for (int i = 0; i < 2 * (v + 1); i++) begin
          @(negedge clk);
          if (i == 0) chk(out_f == 1 && run_f == 1, "R3 start high", out_f, 1);
          if (i == 2 * (v + 1) - 1) div_val = '0;
          if (h > v)
            chk(out_f == exp_frame(i, v, h), "R6 clamp frame", out_f, exp_frame(i, v, h));
          else
            chk(out_f == exp_frame(i, v, h), "R5 R4 frame", out_f, exp_frame(i, v, h));
          chk(out_h == exp_half(i, v), "R7 R4 half", out_h, exp_half(i, v));
        end
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk(out_f == 0 && out_h == 0, "R9 stop at boundary", out_f, 0);
          chk(run_f == 0 && run_h == 0, "R10 running clear", run_f, 0);
        end
      end
    end

    // R8: mid-period change: v=5 h=2, then v=3 h=3 after three cycles
    div_val = 4'd5; high_val = 4'd2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 2) begin div_val = 4'd3; high_val = 4'd3; end
      chk(out_f == exp_frame(i, 5, 2), "R8 old period kept", out_f, exp_frame(i, 5, 2));
      chk(run_f == 1, "R10 running set", run_f, 1);
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(out_f == 1, "R8 new full high", out_f, 1);
      chk(out_h == exp_half(i, 3), "R8 new half", out_h, exp_half(i, 3));
    end
    // R9: stop requested mid-period waits for the boundary
    div_val = 4'd7; high_val = 4'd0;
    @(negedge clk);
    @(negedge clk);
    div_val = '0;
    for (int i = 2; i < 8; i++) begin
      @(negedge clk);
      chk(out_h == exp_half(i, 7), "R9 finish period", out_h, exp_half(i, 7));
      chk(run_h == 1, "R10 still running", run_h, 1);
    end
    repeat (3) begin
      @(negedge clk);
      chk(out_h == 0 && run_h == 0, "R9 R2 stopped", out_h, 0);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule